// File: doc/BRIEF.md
# Program Counter and Status Word Register

This block holds the architectural word that carries both the program counter and the processor status. The word is 32 bits wide. A 24-bit word index sits in the middle of the word and gives a 26-bit byte address whose two low bits are always zero. Above the index are four condition flags and two interrupt-disable bits. Below it is a two-bit execution mode. The separate fields are also driven out on their own pins, so the rest of the core can use flags, masks and mode without slicing the word.

Per cycle the block takes the ALU result, its carry out and its signed overflow. It loads the condition flags from them only when the current instruction's set-flags bit is asserted. It also takes three PC inputs. A sequential advance steps the PC by one instruction. A branch loads a new word index. A whole-word write handles instructions that name this register as a destination; in user mode that write is partly protected. The ALU, decode, memory access and exception entry are outside the block.

Top module: `pc_status_reg`

## Requirements
- R1: A synchronous reset, which overrides every other input, gives word 0x0C000003: flags clear, both interrupt-disable bits set, PC 0, supervisor mode.
- R2: Word layout, from bit 31 down: N, Z, C, V, IRQ-disable, FIQ-disable. Bits 25:2 hold the PC word index and bits 1:0 the mode. Each separate output equals its field of the word, and `pc_addr` is the index followed by two zero bits.
- R3: With `set_flags`=1 and no word write, the next flags are N = result bit 31, Z = (result == 0), C = `alu_cout` and V = `alu_ovf`.
- R4: With `set_flags`=0 and no word write, N, Z, C and V keep their values whatever the ALU inputs are.
- R5: `adv` with no branch and no word write adds 4 to the byte address, wrapping modulo 2^26. Flags, masks and mode are left unchanged.
- R6: `br_en` with no word write loads `br_word` into the PC index and takes priority over `adv`. Masks and mode are left unchanged.
- R7: A word write in a privileged mode loads all 32 bits from `wr_data`.
- R8: A word write in user mode loads only the flags (bits 31:28) and the PC index (bits 25:2). The mask bits and the mode keep their values.
- R9: A word write takes priority over a flag update, a branch and an advance in the same cycle.
- R10: Mode encoding is 00 user, 01 fast interrupt, 10 interrupt and 11 supervisor. Only 00 is unprivileged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_flags | input | 1 | Instruction set-flags bit |
| alu_res | input | 32 | ALU result |
| alu_cout | input | 1 | ALU unsigned carry out |
| alu_ovf | input | 1 | ALU signed overflow |
| wr_en | input | 1 | Whole-word write strobe |
| wr_data | input | 32 | Whole-word write value |
| adv | input | 1 | Sequential PC advance |
| br_en | input | 1 | Branch load strobe |
| br_word | input | 24 | Branch target word index |
| psr_word | output | 32 | Packed word |
| pc_addr | output | 26 | PC byte address |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_off | output | 1 | Normal interrupts disabled |
| fiq_off | output | 1 | Fast interrupts disabled |
| mode | output | 2 | Execution mode |

## Verification
The assertions assume that the ALU inputs are already settled values for the current cycle. They also assume that `wr_en`, `br_en` and `adv` may arrive in any mix, with the priority order in R9 and R6 resolving any combination. The reset assertion is the only one that does not stand down during reset. The stimulus drives every input at the falling edge from fully defined values. It deliberately combines a word write with a flag update, a branch and an advance, and a reset with a pending write, so every priority rule is tested. The vectors also reach the PC wrap point and visit all four modes, so the privilege test covers each encoding.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } cpu_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cond_t;

  typedef struct packed {
    logic irq_off;
    logic fiq_off;
  } mask_t;

  function automatic logic mode_is_priv(cpu_mode_e m);
    return m != MODE_USR;
  endfunction

endpackage

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cond_t             cur_cond,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  input  logic              alu_ovf,
  input  logic              set_flags,
  input  logic              hold,
  output cond_t             nxt_cond,
  output logic              upd_evt
);

  function automatic cond_t calc_cond(logic [DATA_W-1:0] r, logic co, logic ov);
    cond_t f;
    f.n = r[DATA_W-1];
    f.z = ~|r;
    f.c = co;
    f.v = ov;
    return f;
  endfunction

  assign upd_evt  = set_flags & ~hold;
  assign nxt_cond = upd_evt ? calc_cond(alu_res, alu_cout, alu_ovf) : cur_cond;

endmodule

// File: rtl/psw_pc_unit.sv
module psw_pc_unit #(
  parameter int PCF_W = 24
) (
  input  logic [PCF_W-1:0] cur_pcf,
  input  logic             adv,
  input  logic             br_en,
  input  logic [PCF_W-1:0] br_word,
  input  logic             hold,
  output logic [PCF_W-1:0] nxt_pcf,
  output logic             step_evt,
  output logic             br_evt
);

  function automatic logic [PCF_W-1:0] pc_inc(logic [PCF_W-1:0] p);
    return p + PCF_W'(1);
  endfunction

  assign br_evt   = br_en & ~hold;
  assign step_evt = adv & ~br_en & ~hold;

  always_comb begin
    nxt_pcf = cur_pcf;
    if (br_evt)        nxt_pcf = br_word;
    else if (step_evt) nxt_pcf = pc_inc(cur_pcf);
  end

endmodule

// File: rtl/psw_wr_unit.sv
module psw_wr_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 26,
  localparam int PCF_W = ADDR_W - 2
) (
  input  logic [DATA_W-1:0] wr_data,
  input  cond_t             cur_cond,
  input  mask_t             cur_mask,
  input  cpu_mode_e         cur_mode,
  input  logic [PCF_W-1:0]  cur_pcf,
  input  logic              wr_en,
  output cond_t             w_cond,
  output mask_t             w_mask,
  output cpu_mode_e         w_mode,
  output logic [PCF_W-1:0]  w_pcf,
  output logic              priv,
  output logic              wr_evt
);

  localparam int COND_HI = DATA_W - 1;
  localparam int MASK_HI = DATA_W - 5;

  assign priv   = mode_is_priv(cur_mode);
  assign wr_evt = wr_en;

  always_comb begin
    w_cond = cur_cond;
    w_mask = cur_mask;
    w_mode = cur_mode;
    w_pcf  = cur_pcf;
    if (wr_en) begin
      w_cond = cond_t'(wr_data[COND_HI -: 4]);
      w_pcf  = wr_data[ADDR_W-1:2];
      if (priv) begin
        w_mask = mask_t'(wr_data[MASK_HI -: 2]);
        w_mode = cpu_mode_e'(wr_data[1:0]);
      end
    end
  end

endmodule

// File: rtl/pc_status_reg.sv
module pc_status_reg
  import psw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 26,
  localparam int PCF_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  input  logic              alu_ovf,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              adv,
  input  logic              br_en,
  input  logic [PCF_W-1:0]  br_word,
  output logic [DATA_W-1:0] psr_word,
  output logic [ADDR_W-1:0] pc_addr,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic              irq_off,
  output logic              fiq_off,
  output logic [1:0]        mode
);

  localparam logic [DATA_W-1:0] RST_WORD =
    {4'b0000, 2'b11, {PCF_W{1'b0}}, MODE_SVC};

  cond_t            cond_q, cond_fl, cond_wr;
  mask_t            mask_q, mask_wr;
  cpu_mode_e        mode_q, mode_wr;
  logic [PCF_W-1:0] pcf_q, pcf_pc, pcf_wr;

  // named internal events
  logic flag_upd_evt, pc_step_evt, br_evt, wr_evt, priv;

  psw_flag_unit #(.DATA_W(DATA_W)) u_flag (
    .cur_cond (cond_q),
    .alu_res  (alu_res),
    .alu_cout (alu_cout),
    .alu_ovf  (alu_ovf),
    .set_flags(set_flags),
    .hold     (wr_en),
    .nxt_cond (cond_fl),
    .upd_evt  (flag_upd_evt)
  );

  psw_pc_unit #(.PCF_W(PCF_W)) u_pc (
    .cur_pcf (pcf_q),
    .adv     (adv),
    .br_en   (br_en),
    .br_word (br_word),
    .hold    (wr_en),
    .nxt_pcf (pcf_pc),
    .step_evt(pc_step_evt),
    .br_evt  (br_evt)
  );

  psw_wr_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
    .wr_data (wr_data),
    .cur_cond(cond_q),
    .cur_mask(mask_q),
    .cur_mode(mode_q),
    .cur_pcf (pcf_q),
    .wr_en   (wr_en),
    .w_cond  (cond_wr),
    .w_mask  (mask_wr),
    .w_mode  (mode_wr),
    .w_pcf   (pcf_wr),
    .priv    (priv),
    .wr_evt  (wr_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      mask_q <= '1;
      mode_q <= MODE_SVC;
      pcf_q  <= '0;
    end else if (wr_evt) begin
      cond_q <= cond_wr;
      mask_q <= mask_wr;
      mode_q <= mode_wr;
      pcf_q  <= pcf_wr;
    end else begin
      cond_q <= cond_fl;
      pcf_q  <= pcf_pc;
    end
  end

  assign psr_word = {cond_q, mask_q, pcf_q, mode_q};
  assign pc_addr  = {pcf_q, 2'b00};
  assign flag_n   = cond_q.n;
  assign flag_z   = cond_q.z;
  assign flag_c   = cond_q.c;
  assign flag_v   = cond_q.v;
  assign irq_off  = mask_q.irq_off;
  assign fiq_off  = mask_q.fiq_off;
  assign mode     = mode_q;

  // R1
  reset_word_chk: assert property (@(posedge clk)
    rst |=> psr_word == RST_WORD);

  // R3
  flags_load_chk: assert property (@(posedge clk) disable iff (rst)
    flag_upd_evt |=> cond_q == {$past(alu_res[DATA_W-1]), ($past(alu_res) == '0),
                                $past(alu_cout), $past(alu_ovf)});

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !set_flags) |=> $stable(cond_q));

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    pc_step_evt |=> pc_addr == ADDR_W'($past(pc_addr) + 4));

  // R5 R6
  status_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(mask_q) && $stable(mode_q)));

  // R6
  branch_load_chk: assert property (@(posedge clk) disable iff (rst)
    br_evt |=> pcf_q == $past(br_word));

  // R7
  priv_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && priv) |=> psr_word == $past(wr_data));

  // R8
  user_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !priv) |=> ($stable(mask_q) && $stable(mode_q) &&
                           cond_q == $past(wr_data[DATA_W-1 -: 4])));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (set_flags || adv || br_en)) |=> pcf_q == $past(wr_data[ADDR_W-1:2]));

  // R10
  priv_decode_chk: assert property (@(posedge clk) disable iff (rst)
    priv == (mode != 2'b00));

endmodule

// File: tb/pc_status_reg_tb.sv
`timescale 1ns/1ps
module pc_status_reg_tb;

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic        sf;
    logic [31:0] res;
    logic        co;
    logic        ov;
    logic        adv;
    logic        br;
    logic [23:0] bw;
    logic [31:0] exp;
  } vec_t;

  // sequential vectors from the reset word 0x0C000003
  localparam vec_t VECS [0:9] = '{
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 24'h0,      32'h0C000007}, // R5 advance
    '{1'b0, 32'h0,         1'b1, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 24'h0,      32'h6C000007}, // R3 Z,C
    '{1'b0, 32'h0,         1'b0, 32'h80000000, 1'b0, 1'b1, 1'b1, 1'b0, 24'h0,      32'h6C00000B}, // R4 hold, R5
    '{1'b0, 32'h0,         1'b1, 32'h80000001, 1'b0, 1'b1, 1'b1, 1'b1, 24'h000400, 32'h9C001003}, // R3 N,V R6 branch wins
    '{1'b1, 32'h20005678, 1'b1, 32'h0,         1'b1, 1'b1, 1'b1, 1'b1, 24'h000111, 32'h20005678}, // R7 R9
    '{1'b1, 32'hFFFFFFFF, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 24'h0,      32'hF3FFFFFC}, // R8 user write
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 24'h0,      32'hF0000000}, // R5 wrap
    '{1'b0, 32'h0,         1'b1, 32'h7FFFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 24'h0,      32'h20000000}, // R3 C only
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 24'hFFFFFF, 32'h23FFFFFC}, // R6 top
    '{1'b1, 32'h0C000003, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 24'h0,      32'h00000000}  // R8 R10 user
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        set_flags, alu_cout, alu_ovf, wr_en, adv, br_en;
  logic [31:0] alu_res, wr_data;
  logic [23:0] br_word;
  logic [31:0] psr_word;
  logic [25:0] pc_addr;
  logic        flag_n, flag_z, flag_c, flag_v, irq_off, fiq_off;
  logic [1:0]  mode;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pc_status_reg u_dut (
    .clk(clk), .rst(rst), .set_flags(set_flags), .alu_res(alu_res),
    .alu_cout(alu_cout), .alu_ovf(alu_ovf), .wr_en(wr_en), .wr_data(wr_data),
    .adv(adv), .br_en(br_en), .br_word(br_word), .psr_word(psr_word),
    .pc_addr(pc_addr), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .irq_off(irq_off), .fiq_off(fiq_off), .mode(mode)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // R2: separate outputs must agree with word fields
  task automatic chk_fields();
    logic [31:0] sep;
    sep = {flag_n, flag_z, flag_c, flag_v, irq_off, fiq_off, pc_addr[25:2], mode};
    chk("R2 fields", sep, psr_word);
    chk("R2 pc_addr", {6'd0, pc_addr}, {6'd0, psr_word[25:2], 2'b00});
  endtask

  task automatic idle();
    set_flags = 0; alu_res = 0; alu_cout = 0; alu_ovf = 0;
    wr_en = 0; wr_data = 0; adv = 0; br_en = 0; br_word = 0;
  endtask

  task automatic step_write(logic [31:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R1 reset word", psr_word, 32'h0C000003);
    chk_fields();

    for (int i = 0; i < 10; i++) begin
      wr_en = VECS[i].wr; wr_data = VECS[i].wd; set_flags = VECS[i].sf;
      alu_res = VECS[i].res; alu_cout = VECS[i].co; alu_ovf = VECS[i].ov;
      adv = VECS[i].adv; br_en = VECS[i].br; br_word = VECS[i].bw;
      @(negedge clk);
      idle();
      chk($sformatf("vector %0d", i), psr_word, VECS[i].exp);
      chk_fields();
    end

    // R1: reset beats a pending write
    rst = 1; wr_en = 1; wr_data = 32'hFFFFFFFF; adv = 1;
    @(negedge clk);
    idle(); rst = 0;
    chk("R1 reset over write", psr_word, 32'h0C000003);

    // R10: walk privileged modes, then drop to user
    step_write(32'h00000001);
    chk("R10 svc->fiq", psr_word, 32'h00000001);
    step_write(32'hC0000012);
    chk("R10 fiq privileged", psr_word, 32'hC0000012);
    step_write(32'h0C000000);
    chk("R10 irq privileged", psr_word, 32'h0C000000);
    step_write(32'h00000003);
    chk("R8 R10 user protected", psr_word, 32'h0C000000);
    chk("R10 user mode out", {30'd0, mode}, 32'd0);

    // R4: ALU activity without set_flags leaves flags
    set_flags = 0; alu_res = 32'h0; alu_cout = 1; alu_ovf = 1;
    @(negedge clk);
    idle();
    chk("R4 flags kept", psr_word, 32'h0C000000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule